// File: doc/BRIEF.md
# Two-Channel Descriptor-Chain Cipher DMA Controller

This controller executes chains of descriptors held in memory on behalf of a block cipher datapath. Each descriptor is three 32-bit words. The first is control and status, the second is the source address and the third is the destination. A descriptor does one of two jobs:

- **Key load:** it copies one 16-byte slot of key or IV material into a per-channel key store.
- **Data:** it streams 16-byte blocks from the source, through the cipher port, and out to the destination.

A single chain can therefore program a key and an IV and then process data. The cipher itself sits outside the block. The controller hands it one 128-bit block at a time, together with the key store, the algorithm code, the block-chaining mode, the direction, and a flag marking the first block of a descriptor. It then takes back one 128-bit result.

Two channels run independently. Software starts a channel by writing the chain base address, with bit 1 set, to that channel's register. The channels share one memory port and one execution engine, which takes turns between them at descriptor granularity. When a chain ends, the controller latches a nonzero completion code in the channel's status register and holds that channel's interrupt high until software clears it.

Top module: `chain_cipher_dma`

## Requirements
- R1: After reset, both interrupts are low, both status registers read 0, both channel registers read with bit 0 (busy) clear, and no memory request is made.
- R2: Writing a value with bit 1 set to register address n (0 or 1) starts channel n at that value with bits 1:0 cleared. Channel register reads return the current descriptor pointer in bits 31:2 and busy in bit 0. A write with bit 1 clear has no effect, and a start write to a channel that is busy has no effect.
- R3: A descriptor is fetched as control, source, destination from pointer+0, +4, +8, and the next descriptor sits at pointer+12. Before acting on a descriptor, the controller rewrites its control word in memory with bit 31 (owner) cleared and all other bits kept.
- R4: A descriptor whose owner bit 31 is 0 is not acted on: no memory write occurs, and the chain ends with status 5.
- R5: A descriptor with mode field (bits 23:20) equal to 1 copies four words from the source into key slot k = destination bits 5:4 (byte offset 0, 16 or 32). Word i lands in cph_key bits [128k+32i +: 32].
- R6: Any other mode is a data descriptor of length/16 blocks, with the length in bits 16:0. Block b is read from source+16b, with word i in bits [32i +: 32]. It is presented with cph_mode = bits 23:20, cph_bmode = bits 27:26, cph_enc = bit 28, and cph_first set only for b = 0. The returned block is written to destination+16b.
- R7: A descriptor with bit 18 set is the last one. After it completes, the status becomes 1 and the channel goes idle.
- R8: The status register of channel n is at address 4+n, and irq[n] is high exactly while it is nonzero. Writing 0xF clears it; writing any other value leaves it unchanged.
- R9: A data descriptor whose length is not a multiple of 16 gets bit 30 (error) set in its written-back control word. No data moves for it, and the chain ends with status 3.
- R10: If the 64th descriptor of a chain lacks bit 18, it is not executed. It gets bit 30 set in its written-back control word, and the chain ends with status 3.
- R11: While both channels are busy, consecutive descriptors are taken alternately from channel 0 and channel 1, with channel 0 served first after reset.
- R12: mem_addr, mem_we and mem_wdata stay stable while mem_req waits for mem_ack. cph_in_data stays stable while cph_in_valid waits for cph_in_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 2 | Per-channel completion interrupt |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when 1, read when 0 |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Memory read data |
| cph_in_valid | output | 1 | Block offered to cipher |
| cph_in_ready | input | 1 | Cipher accepts block |
| cph_in_data | output | 128 | Input block |
| cph_first | output | 1 | First block of a data descriptor |
| cph_mode | output | 4 | Algorithm and key-size code |
| cph_bmode | output | 2 | Block-chaining mode |
| cph_enc | output | 1 | 1 encrypt, 0 decrypt |
| cph_key | output | KEY_SLOTS*128 | Key store of the active channel |
| cph_out_valid | input | 1 | Result block valid |
| cph_out_ready | output | 1 | Controller accepts result |
| cph_out_data | input | 128 | Result block |

## Verification
The hardest situation to reach from the ports is a start write that lands on a channel while it is mid-chain. It needs the chain to stay in flight for a known span. The bench holds the cipher stub's ready low, so channel 0 parks with its first block offered. It then issues a second start to the same channel, and a bit-1-clear write to the other channel. Finally it releases the stall and confirms that the second chain's descriptor was never claimed. The 64-entry overflow is reached with a chain of short key-load descriptors, which keeps that run brief.

// File: rtl/chain_cipher_dma.sv
module chain_cipher_dma #(
  parameter int MAX_DESC  = 64,
  parameter int KEY_SLOTS = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [2:0]               reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  output logic [1:0]               irq,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [31:0]              mem_addr,
  output logic [31:0]              mem_wdata,
  input  logic                     mem_ack,
  input  logic [31:0]              mem_rdata,
  output logic                     cph_in_valid,
  input  logic                     cph_in_ready,
  output logic [127:0]             cph_in_data,
  output logic                     cph_first,
  output logic [3:0]               cph_mode,
  output logic [1:0]               cph_bmode,
  output logic                     cph_enc,
  output logic [KEY_SLOTS*128-1:0] cph_key,
  input  logic                     cph_out_valid,
  output logic                     cph_out_ready,
  input  logic [127:0]             cph_out_data
);
  localparam int CW = $clog2(MAX_DESC);
  localparam int KW = KEY_SLOTS * 128;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_CLAIM, S_KEY, S_BRD, S_SEND, S_RECV, S_BWR, S_STEP, S_END
  } state_t;

  state_t          state;
  logic [1:0]      ch_busy;
  logic [31:0]     ch_ptr [2];
  logic [CW-1:0]   ch_cnt [2];
  logic [2:0]      ch_stat [2];
  logic [KW-1:0]   key_st [2];
  logic            act, rr_last;
  logic [1:0]      widx;
  logic [31:0]     d_ctrl, d_src, d_dst;
  logic [12:0]     blk;
  logic [127:0]    blk_buf;
  logic [2:0]      end_code;

  wire        pick     = ch_busy[!rr_last] ? !rr_last : rr_last;
  wire        is_key   = d_ctrl[23:20] == 4'd1;
  wire        err_len  = !is_key && (d_ctrl[3:0] != 4'd0);
  wire        err_max  = (ch_cnt[act] == CW'(MAX_DESC - 1)) && !d_ctrl[18];
  wire        desc_err = err_len || err_max;
  wire [12:0] nblk     = d_ctrl[16:4];
  wire [31:0] blk_off  = {15'd0, blk, 4'd0};
  wire [31:0] w_off    = {28'd0, widx, 2'd0};
  wire [1:0]  slot     = d_dst[5:4];

  assign irq[0]        = ch_stat[0] != 3'd0;
  assign irq[1]        = ch_stat[1] != 3'd0;
  assign cph_in_valid  = state == S_SEND;
  assign cph_out_ready = state == S_RECV;
  assign cph_in_data   = blk_buf;
  assign cph_first     = blk == 13'd0;
  assign cph_mode      = d_ctrl[23:20];
  assign cph_bmode     = d_ctrl[27:26];
  assign cph_enc       = d_ctrl[28];
  assign cph_key       = key_st[act];

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {ch_ptr[0][31:2], 1'b0, ch_busy[0]};
      3'd1:    reg_rdata = {ch_ptr[1][31:2], 1'b0, ch_busy[1]};
      3'd4:    reg_rdata = {29'd0, ch_stat[0]};
      3'd5:    reg_rdata = {29'd0, ch_stat[1]};
      default: reg_rdata = 32'd0;
    endcase
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = 32'd0;
    mem_wdata = 32'd0;
    case (state)
      S_FETCH: begin mem_req = 1'b1; mem_addr = ch_ptr[act] + w_off; end
      S_CLAIM: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ch_ptr[act];
        mem_wdata = {1'b0, d_ctrl[30] | desc_err, d_ctrl[29:0]};
      end
      S_KEY:   begin mem_req = 1'b1; mem_addr = d_src + w_off; end
      S_BRD:   begin mem_req = 1'b1; mem_addr = d_src + blk_off + w_off; end
      S_BWR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = d_dst + blk_off + w_off;
        mem_wdata = blk_buf[32*widx +: 32];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      ch_busy  <= 2'b00;
      act      <= 1'b0;
      rr_last  <= 1'b1;
      widx     <= 2'd0;
      d_ctrl   <= 32'd0;
      d_src    <= 32'd0;
      d_dst    <= 32'd0;
      blk      <= 13'd0;
      blk_buf  <= 128'd0;
      end_code <= 3'd0;
      for (int n = 0; n < 2; n++) begin
        ch_ptr[n]  <= 32'd0;
        ch_cnt[n]  <= '0;
        ch_stat[n] <= 3'd0;
        key_st[n]  <= '0;
      end
    end else begin
      for (int n = 0; n < 2; n++) begin
        if (reg_we && reg_addr == 3'(n) && reg_wdata[1] && !ch_busy[n]) begin
          ch_busy[n] <= 1'b1;
          ch_ptr[n]  <= {reg_wdata[31:2], 2'b00};
          ch_cnt[n]  <= '0;
        end
        if (reg_we && reg_addr == 3'(4 + n) && reg_wdata == 32'hF)
          ch_stat[n] <= 3'd0;
      end

      case (state)
        S_IDLE: if (ch_busy != 2'b00) begin
          act     <= pick;
          rr_last <= pick;
          widx    <= 2'd0;
          state   <= S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          widx <= widx + 2'd1;
          case (widx)
            2'd0:    d_ctrl <= mem_rdata;
            2'd1:    d_src  <= mem_rdata;
            default: begin
              d_dst <= mem_rdata;
              widx  <= 2'd0;
              if (d_ctrl[31]) state <= S_CLAIM;
              else begin end_code <= 3'd5; state <= S_END; end
            end
          endcase
        end
        S_CLAIM: if (mem_ack) begin
          widx <= 2'd0;
          blk  <= 13'd0;
          if (desc_err)             begin end_code <= 3'd3; state <= S_END; end
          else if (is_key)          state <= S_KEY;
          else if (nblk == 13'd0)   state <= S_STEP;
          else                      state <= S_BRD;
        end
        S_KEY: if (mem_ack) begin
          if (int'(slot) < KEY_SLOTS)
            key_st[act][int'(slot)*128 + int'(widx)*32 +: 32] <= mem_rdata;
          widx <= widx + 2'd1;
          if (widx == 2'd3) state <= S_STEP;
        end
        S_BRD: if (mem_ack) begin
          blk_buf[32*widx +: 32] <= mem_rdata;
          widx <= widx + 2'd1;
          if (widx == 2'd3) state <= S_SEND;
        end
        S_SEND: if (cph_in_ready) state <= S_RECV;
        S_RECV: if (cph_out_valid) begin
          blk_buf <= cph_out_data;
          widx    <= 2'd0;
          state   <= S_BWR;
        end
        S_BWR: if (mem_ack) begin
          widx <= widx + 2'd1;
          if (widx == 2'd3) begin
            if (blk == nblk - 13'd1) state <= S_STEP;
            else begin blk <= blk + 13'd1; state <= S_BRD; end
          end
        end
        S_STEP: begin
          if (d_ctrl[18]) begin
            end_code <= 3'd1;
            state    <= S_END;
          end else begin
            ch_ptr[act] <= ch_ptr[act] + 32'd12;
            ch_cnt[act] <= ch_cnt[act] + 1'b1;
            state       <= S_IDLE;
          end
        end
        S_END: begin
          ch_stat[act] <= end_code;
          ch_busy[act] <= 1'b0;
          state        <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module chain_cipher_dma_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_we,
  input logic [2:0]   reg_addr,
  input logic [31:0]  reg_wdata,
  input logic [1:0]   irq,
  input logic         mem_req,
  input logic         mem_we,
  input logic [31:0]  mem_addr,
  input logic [31:0]  mem_wdata,
  input logic         mem_ack,
  input logic         cph_in_valid,
  input logic         cph_in_ready,
  input logic [127:0] cph_in_data
);
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R12
  AST_CPH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cph_in_valid && !cph_in_ready |=> cph_in_valid && $stable(cph_in_data)); // R12
  AST_IRQ0_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq[0] && !(reg_we && reg_addr == 3'd4 && reg_wdata == 32'hF) |=> irq[0]); // R8
  AST_IRQ1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq[1] && !(reg_we && reg_addr == 3'd5 && reg_wdata == 32'hF) |=> irq[1]); // R8
endmodule

bind chain_cipher_dma chain_cipher_dma_chk u_chk (.*);

// File: tb/chain_cipher_dma_tb.sv
`timescale 1ns/1ps
module chain_cipher_dma_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic         reg_we = 1'b0;
  logic [2:0]   reg_addr = 3'd0;
  logic [31:0]  reg_wdata = 32'd0;
  logic [31:0]  reg_rdata;
  logic [1:0]   irq;
  logic         mem_req, mem_we, mem_ack;
  logic [31:0]  mem_addr, mem_wdata, mem_rdata;
  logic         cph_in_valid, cph_in_ready, cph_first, cph_enc, cph_out_valid, cph_out_ready;
  logic [127:0] cph_in_data, cph_out_data;
  logic [3:0]   cph_mode;
  logic [1:0]   cph_bmode;
  logic [383:0] cph_key;

  chain_cipher_dma u_dut (.*);

  logic [31:0] mem [0:1023];
  logic [31:0] wlog [0:15];
  int wr_cnt = 0, log_n = 0, hs_err = 0;
  logic log_en = 1'b0;
  logic stall = 1'b0;
  logic pend = 1'b0;
  logic [127:0] res = '0;
  int errs = 0, checks = 0;

  assign mem_rdata = mem[mem_addr[11:2]];
  always @(posedge clk or negedge rst_n)
    if (!rst_n) mem_ack <= 1'b0;
    else        mem_ack <= mem_req && !mem_ack;
  always @(posedge clk)
    if (mem_ack && mem_we) begin
      mem[mem_addr[11:2]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
      if (log_en && log_n < 16) begin wlog[log_n] <= mem_addr; log_n <= log_n + 1; end
    end

  assign cph_in_ready  = !stall;
  assign cph_out_valid = pend;
  assign cph_out_data  = res;
  always @(posedge clk) begin
    if (cph_in_valid && cph_in_ready) begin
      pend <= 1'b1;
      res  <= cph_in_data ^ cph_key[127:0] ^ cph_key[383:256] ^
              {120'd0, cph_mode, cph_first, cph_bmode, cph_enc};
    end else if (cph_out_ready && pend) pend <= 1'b0;
  end

  logic prev_pend = 1'b0;
  logic [31:0] prev_addr = 32'd0;
  logic prev_we = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (prev_pend && (mem_addr != prev_addr || mem_we != prev_we || !mem_req)) hs_err++;
    prev_pend = mem_req && !mem_ack;
    prev_addr = mem_addr;
    prev_we   = mem_we;
  end

  function automatic logic [31:0] ctl(bit own, bit eoc, logic [3:0] md, logic [1:0] bm, bit enc, logic [16:0] len);
    return {own, 1'b0, 1'b0, enc, bm, 2'b00, md, 1'b0, eoc, 1'b0, len};
  endfunction
  function automatic logic [31:0] kw(int i);  return 32'hA5A50000 | i; endfunction
  function automatic logic [31:0] ivw(int i); return 32'h3C3C0100 | i; endfunction
  function automatic logic [31:0] sw(int b, int i); return 32'h0BAD0000 | (b << 8) | i; endfunction

  task automatic chk(string req, logic [31:0] actual, logic [31:0] expv);
    checks++;
    if (actual !== expv) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, actual, expv);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic wait_irq(int ch, string req);
    int n = 0;
    while (!irq[ch] && n < 20000) begin @(negedge clk); n++; end
    chk(req, {31'd0, irq[ch]}, 32'd1);
  endtask

  task automatic put_desc(int a, logic [31:0] c, logic [31:0] s, logic [31:0] d);
    mem[a >> 2] = c; mem[(a >> 2) + 1] = s; mem[(a >> 2) + 2] = d;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", {30'd0, irq}, 32'd0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
    rd(3'd4, v); chk("R1 stat0", v, 0);
    rd(3'd5, v); chk("R1 stat1", v, 0);
    rd(3'd0, v); chk("R1 busy0", v & 1, 0);
  endtask

  task automatic t_key_data();
    logic [31:0] v, c2;
    c2 = ctl(1, 1, 4'hA, 2'd1, 1, 17'd32);
    put_desc('h000, ctl(1, 0, 4'h1, 0, 0, 17'd16), 'h100, 0);
    put_desc('h00C, ctl(1, 0, 4'h1, 0, 0, 17'd16), 'h110, 32);
    put_desc('h018, c2, 'h200, 'h300);
    wr(3'd0, 32'h0000_0003);
    wait_irq(0, "R7 irq");
    rd(3'd4, v); chk("R7 status done", v, 1);
    rd(3'd0, v); chk("R2 ptr at last desc, idle", v, 32'h18);
    chk("R3 claim d0", mem['h000 >> 2], ctl(0, 0, 4'h1, 0, 0, 17'd16));
    chk("R3 claim d2", mem['h018 >> 2], c2 & 32'h7FFF_FFFF);
    chk("R5 key slot0 word3", cph_key[127:96], kw(3));
    chk("R5 key slot2 word1", cph_key[319:288], ivw(1));
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 4; i++)
        chk($sformatf("R6 blk%0d w%0d", b, i), mem[('h300 >> 2) + 4*b + i],
            sw(b, i) ^ kw(i) ^ ivw(i) ^ ((i == 0) ? (b == 0 ? 32'hAB : 32'hA3) : 0));
    wr(3'd4, 32'h1);
    chk("R8 other value keeps irq", {31'd0, irq[0]}, 1);
    wr(3'd4, 32'hF);
    chk("R8 clear drops irq", {31'd0, irq[0]}, 0);
  endtask

  task automatic t_owner();
    logic [31:0] v, c;
    int w0;
    c = ctl(0, 1, 4'h8, 0, 1, 17'd16);
    put_desc('h800, c, 'h200, 'h900);
    mem['h900 >> 2] = 32'h5555AAAA;
    w0 = wr_cnt;
    wr(3'd1, 32'h802);
    wait_irq(1, "R4 irq");
    rd(3'd5, v); chk("R4 status", v, 5);
    chk("R4 ctrl untouched", mem['h800 >> 2], c);
    chk("R4 no writes", wr_cnt - w0, 0);
    wr(3'd5, 32'hF);
  endtask

  task automatic t_badlen();
    logic [31:0] v, c;
    c = ctl(1, 1, 4'h8, 0, 1, 17'd20);
    put_desc('h840, c, 'h200, 'h940);
    mem['h940 >> 2] = 32'h12345678;
    wr(3'd0, 32'h842);
    wait_irq(0, "R9 irq");
    rd(3'd4, v); chk("R9 status", v, 3);
    chk("R9 error bit", mem['h840 >> 2], (c & 32'h7FFF_FFFF) | 32'h4000_0000);
    chk("R9 dst untouched", mem['h940 >> 2], 32'h12345678);
    wr(3'd4, 32'hF);
  endtask

  task automatic t_long();
    logic [31:0] v, c;
    c = ctl(1, 0, 4'h1, 0, 0, 17'd16);
    for (int k = 0; k < 64; k++) put_desc('h400 + 12*k, c, 'h100, 0);
    wr(3'd1, 32'h402);
    wait_irq(1, "R10 irq");
    rd(3'd5, v); chk("R10 status", v, 3);
    chk("R10 d63 error", mem[('h400 + 12*63) >> 2], (c & 32'h7FFF_FFFF) | 32'h4000_0000);
    chk("R10 d62 clean", mem[('h400 + 12*62) >> 2], c & 32'h7FFF_FFFF);
    wr(3'd5, 32'hF);
  endtask

  task automatic t_rr();
    put_desc('hA00, ctl(1, 0, 4'h1, 0, 0, 17'd16), 'h100, 0);
    put_desc('hA0C, ctl(1, 1, 4'h1, 0, 0, 17'd16), 'h100, 0);
    put_desc('hA40, ctl(1, 0, 4'h1, 0, 0, 17'd16), 'h110, 32);
    put_desc('hA4C, ctl(1, 1, 4'h1, 0, 0, 17'd16), 'h110, 32);
    log_n = 0; log_en = 1'b1;
    wr(3'd0, 32'hA02);
    wr(3'd1, 32'hA42);
    wait_irq(0, "R11 irq0");
    wait_irq(1, "R11 irq1");
    log_en = 1'b0;
    chk("R11 order 0", wlog[0], 32'hA00);
    chk("R11 order 1", wlog[1], 32'hA40);
    chk("R11 order 2", wlog[2], 32'hA0C);
    chk("R11 order 3", wlog[3], 32'hA4C);
    wr(3'd4, 32'hF); wr(3'd5, 32'hF);
  endtask

  task automatic t_busy_start();
    logic [31:0] v, c2;
    put_desc('hB00, ctl(1, 1, 4'h8, 2'd0, 0, 17'd16), 'h200, 'hC00);
    c2 = ctl(1, 1, 4'h1, 0, 0, 17'd16);
    put_desc('hB40, c2, 'h110, 0);
    stall = 1'b1;
    wr(3'd0, 32'hB02);
    repeat (40) @(negedge clk);
    wr(3'd0, 32'hB42);
    wr(3'd1, 32'hB40);
    rd(3'd0, v); chk("R2 busy restart ignored", v, 32'hB01);
    rd(3'd1, v); chk("R2 no-flag write ignored", v & 1, 0);
    stall = 1'b0;
    wait_irq(0, "R2 irq");
    chk("R2 second chain untouched", mem['hB40 >> 2], c2);
    for (int i = 0; i < 4; i++)
      chk($sformatf("R6 ecb dec w%0d", i), mem[('hC00 >> 2) + i],
          sw(0, i) ^ kw(i) ^ ivw(i) ^ ((i == 0) ? 32'h88 : 0));
    wr(3'd4, 32'hF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'd0;
    for (int i = 0; i < 4; i++) begin
      mem[('h100 >> 2) + i] = kw(i);
      mem[('h110 >> 2) + i] = ivw(i);
      mem[('h200 >> 2) + i] = sw(0, i);
      mem[('h210 >> 2) + i] = sw(1, i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_key_data();
    t_owner();
    t_badlen();
    t_long();
    t_rr();
    t_busy_start();
    chk("R12 memory handshake held", hs_err, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule